// File: doc/BRIEF.md
# Cyclic Period Buffer Address Generator

This block produces the byte address of every word that a DMA engine moves into or out of a circular audio buffer in memory. The buffer holds a programmed number of periods, each of a programmed byte size, laid out back to back from a buffer base address. A start pulse loads the configuration and places the first address on the output. Each advance strobe then consumes the current address and moves to the next one. After the last word of the last period, the generator wraps to the base address and keeps going.

Two layouts are supported. In the packed layout, one frame holds one sample from each channel in turn, and every word sits 4 bytes after the one before it. In the split layout, each period is divided into equal regions, one per channel, spaced by a channel offset. The generator visits the channels in turn, taking one word from each region per round, and every region's pointer moves 4 bytes after each full round. A new base address may be presented at any time while the block runs, but it is used only when the buffer wraps. Single-cycle pulses mark the end of each period and the end of each whole buffer. A 25-bit counter reports the bytes moved since the last wrap.

Top module: `cyclic_addr_gen`

## Requirements
- R1: While reset is asserted, and on leaving it, `active_o`, `addr_o`, `byte_cnt_o`, `period_done_o` and `buffer_done_o` are all zero.
- R2: When idle, a `start_i` pulse with a nonzero period size and a nonzero period count captures the configuration. In the next cycle `active_o` is 1 and `addr_o` equals the base address.
- R3: When idle, a `start_i` pulse with a zero period size or a zero period count is ignored: `active_o`, `addr_o` and `byte_cnt_o` stay at zero.
- R4: Packed layout (`cfg_split_i` = 0): word j of period p is at base + p·size + 4·j.
- R5: Split layout (`cfg_split_i` = 1): word j of period p is at base + p·size + (j mod N)·offset + 4·(j div N), where N is `cfg_nch_i` and offset is `cfg_choff_i`. The offset must equal size / N.
- R6: The address moves only in a cycle where `adv_i` is high while active. Otherwise it holds.
- R7: `period_done_o` is high for exactly the one cycle after the advance that consumes the last word of a period.
- R8: After the last word of the last period, `buffer_done_o` pulses together with `period_done_o` and the address returns to the buffer base.
- R9: A change on `cfg_base_i` while running has no effect until the buffer wraps. The wrap samples the value present in the cycle of the wrapping advance.
- R10: `byte_cnt_o` rises by 4 on every advance and becomes 0 on the advance that completes the buffer.
- R11: A `start_i` pulse while active is ignored. The address sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, honoured only when idle |
| adv_i | input | 1 | Consume the current address and advance |
| cfg_base_i | input | 32 | Buffer base address, word aligned |
| cfg_psize_i | input | 16 | Period size in bytes |
| cfg_nper_i | input | 8 | Number of periods in the buffer |
| cfg_choff_i | input | 16 | Byte distance between channel regions (split layout) |
| cfg_nch_i | input | 4 | Number of valid channels |
| cfg_split_i | input | 1 | 0 = packed layout, 1 = split per-channel layout |
| active_o | output | 1 | Generator running |
| addr_o | output | 32 | Address of the current word |
| period_done_o | output | 1 | One-cycle pulse after a period completes |
| buffer_done_o | output | 1 | One-cycle pulse after the whole buffer completes |
| byte_cnt_o | output | 25 | Bytes moved since the last buffer wrap |

## Verification
The bench sweeps both layouts over every channel count of 2, 4, 6 and 8, period counts of 1 to 3, and two period sizes. In each run it walks two full buffers and predicts every address arithmetically. Mixing the channel count with the period size separates a wrong channel stride from a wrong round stride, and a single-period buffer shows whether period wrap is confused with buffer wrap. The advance strobe is dropped in a repeating pattern to show that the address holds between advances. The base address is changed just after each start, which shows whether it is sampled too early. A start pulse is sent partway through every run, and zero-size and zero-count starts are tried from idle.

// File: rtl/cyclic_addr_gen.sv
module cyclic_addr_gen #(
  parameter int AW  = 32,
  parameter int PSW = 16,
  parameter int NPW = 8,
  parameter int CW  = 25,
  parameter int CHW = 4,
  parameter int WB  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           adv_i,
  input  logic [AW-1:0]  cfg_base_i,
  input  logic [PSW-1:0] cfg_psize_i,
  input  logic [NPW-1:0] cfg_nper_i,
  input  logic [PSW-1:0] cfg_choff_i,
  input  logic [CHW-1:0] cfg_nch_i,
  input  logic           cfg_split_i,
  output logic           active_o,
  output logic [AW-1:0]  addr_o,
  output logic           period_done_o,
  output logic           buffer_done_o,
  output logic [CW-1:0]  byte_cnt_o
);

  localparam logic [PSW:0] STEP = (PSW+1)'(WB);

  logic           active_q, split_q, pdone_q, bdone_q;
  logic [PSW-1:0] psize_q, choff_q;
  logic [NPW-1:0] nper_q, pidx_q;
  logic [CHW-1:0] nch_q, ch_q;
  logic [PSW:0]   pbytes_q, chbase_q, rnd_q;
  logic [AW-1:0]  pstart_q;
  logic [CW-1:0]  cnt_q;

  wire            take      = active_q & adv_i;
  wire            go        = start_i & ~active_q & (cfg_psize_i != '0) & (cfg_nper_i != '0);
  wire [PSW:0]    pbytes_nx = pbytes_q + STEP;
  wire            last_word = pbytes_nx >= {1'b0, psize_q};
  wire            last_per  = ({1'b0, pidx_q} + 1'b1) >= {1'b0, nper_q};
  wire            last_ch   = ({1'b0, ch_q} + 1'b1) >= {1'b0, nch_q};
  wire [PSW:0]    offs      = split_q ? (chbase_q + rnd_q) : pbytes_q;

  assign addr_o        = pstart_q + AW'(offs);
  assign active_o      = active_q;
  assign period_done_o = pdone_q;
  assign buffer_done_o = bdone_q;
  assign byte_cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      split_q  <= 1'b0;
      pdone_q  <= 1'b0;
      bdone_q  <= 1'b0;
      psize_q  <= '0;
      choff_q  <= '0;
      nper_q   <= '0;
      pidx_q   <= '0;
      nch_q    <= '0;
      ch_q     <= '0;
      pbytes_q <= '0;
      chbase_q <= '0;
      rnd_q    <= '0;
      pstart_q <= '0;
      cnt_q    <= '0;
    end else begin
      pdone_q <= 1'b0;
      bdone_q <= 1'b0;
      if (go) begin
        active_q <= 1'b1;
        split_q  <= cfg_split_i;
        psize_q  <= cfg_psize_i;
        choff_q  <= cfg_choff_i;
        nper_q   <= cfg_nper_i;
        nch_q    <= cfg_nch_i;
        pstart_q <= cfg_base_i;
        pidx_q   <= '0;
        ch_q     <= '0;
        pbytes_q <= '0;
        chbase_q <= '0;
        rnd_q    <= '0;
        cnt_q    <= '0;
      end else if (take) begin
        if (last_word) begin
          pbytes_q <= '0;
          ch_q     <= '0;
          chbase_q <= '0;
          rnd_q    <= '0;
          pdone_q  <= 1'b1;
          if (last_per) begin
            pidx_q   <= '0;
            pstart_q <= cfg_base_i;
            bdone_q  <= 1'b1;
            cnt_q    <= '0;
          end else begin
            pidx_q   <= pidx_q + 1'b1;
            pstart_q <= pstart_q + AW'(psize_q);
            cnt_q    <= cnt_q + CW'(WB);
          end
        end else begin
          pbytes_q <= pbytes_nx;
          cnt_q    <= cnt_q + CW'(WB);
          if (last_ch) begin
            ch_q     <= '0;
            chbase_q <= '0;
            rnd_q    <= rnd_q + STEP;
          end else begin
            ch_q     <= ch_q + 1'b1;
            chbase_q <= chbase_q + {1'b0, choff_q};
          end
        end
      end
    end
  end

endmodule

// File: rtl/cyclic_addr_gen_chk.sv
module cyclic_addr_gen_chk #(
  parameter int AW  = 32,
  parameter int PSW = 16,
  parameter int NPW = 8,
  parameter int CW  = 25
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic           adv_i,
  input logic [PSW-1:0] cfg_psize_i,
  input logic [NPW-1:0] cfg_nper_i,
  input logic           active_o,
  input logic [AW-1:0]  addr_o,
  input logic           period_done_o,
  input logic           buffer_done_o,
  input logic [CW-1:0]  byte_cnt_o
);

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!active_o && addr_o == '0 && byte_cnt_o == '0 && !period_done_o && !buffer_done_o));

  a_r3_bad_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && start_i && (cfg_psize_i == '0 || cfg_nper_i == '0)) |=> !active_o);

  a_r6_hold_without_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !adv_i) |=> $stable(addr_o) && $stable(byte_cnt_o));

  a_r7_pulse_needs_adv: assert property (@(posedge clk) disable iff (!rst_n)
    period_done_o |-> $past(adv_i && active_o));

  a_r8_buffer_within_period: assert property (@(posedge clk) disable iff (!rst_n)
    buffer_done_o |-> period_done_o);

  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active_o && adv_i) && !buffer_done_o) |-> byte_cnt_o == $past(byte_cnt_o) + CW'(4));

  a_r10_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    buffer_done_o |-> byte_cnt_o == '0);

  a_r11_stays_active: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |=> active_o);

endmodule

bind cyclic_addr_gen cyclic_addr_gen_chk #(.AW(AW), .PSW(PSW), .NPW(NPW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .adv_i(adv_i),
  .cfg_psize_i(cfg_psize_i), .cfg_nper_i(cfg_nper_i),
  .active_o(active_o), .addr_o(addr_o), .period_done_o(period_done_o),
  .buffer_done_o(buffer_done_o), .byte_cnt_o(byte_cnt_o)
);

// File: tb/sim_cyclic_addr_gen.sv
`timescale 1ns/1ps
module sim_cyclic_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, adv_i = 1'b0;
  logic [31:0] cfg_base_i = '0;
  logic [15:0] cfg_psize_i = '0, cfg_choff_i = '0;
  logic [7:0]  cfg_nper_i = '0;
  logic [3:0]  cfg_nch_i = '0;
  logic        cfg_split_i = 1'b0;
  logic        active_o, period_done_o, buffer_done_o;
  logic [31:0] addr_o;
  logic [24:0] byte_cnt_o;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cyclic_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .adv_i(adv_i),
    .cfg_base_i(cfg_base_i), .cfg_psize_i(cfg_psize_i), .cfg_nper_i(cfg_nper_i),
    .cfg_choff_i(cfg_choff_i), .cfg_nch_i(cfg_nch_i), .cfg_split_i(cfg_split_i),
    .active_o(active_o), .addr_o(addr_o), .period_done_o(period_done_o),
    .buffer_done_o(buffer_done_o), .byte_cnt_o(byte_cnt_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    adv_i = 1'b0; start_i = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_cfg(input bit split, input int nch, input int psize, input int nper);
    logic [31:0] base_a, base_b, base, exp;
    int wpp, total, w, cyc, j, p;
    bit exp_pd, exp_bd;
    base_a = 32'h1000_0000 + 32'(nch * 'h100);
    base_b = 32'h2000_4000 + 32'(psize);
    wpp = psize / 4;
    total = wpp * nper;
    do_reset();
    cfg_split_i = split; cfg_nch_i = 4'(nch); cfg_psize_i = 16'(psize);
    cfg_nper_i = 8'(nper); cfg_choff_i = 16'(psize / nch); cfg_base_i = base_a;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cfg_base_i = base_b;                 // R9: new base offered at once
    chk("R2 active after start", 32'(active_o), 32'd1);
    w = 0; cyc = 0; exp_pd = 0; exp_bd = 0;
    while (w < 2 * total) begin
      p = (w % total) / wpp;
      j = w % wpp;
      base = (w < total) ? base_a : base_b;
      if (split) exp = base + 32'(p * psize + (j % nch) * (psize / nch) + 4 * (j / nch));
      else       exp = base + 32'(p * psize + 4 * j);
      chk(split ? "R5 split address" : "R4 packed address", addr_o, exp);
      chk("R10 byte count", 32'(byte_cnt_o), 32'((w % total) * 4));
      chk("R7 period pulse", 32'(period_done_o), 32'(exp_pd));
      chk("R8 buffer pulse", 32'(buffer_done_o), 32'(exp_bd));
      adv_i   = (cyc % 4) != 3;          // R6: gaps in the strobe
      start_i = (cyc == 5);              // R11: start while running
      exp_pd  = adv_i && (j == wpp - 1);
      exp_bd  = exp_pd && (p == nper - 1);
      if (adv_i) w++;
      cyc++;
      @(negedge clk);
    end
    adv_i = 1'b0; start_i = 1'b0;
    chk("R8 back at base", addr_o, base_b);
    chk("R7 last period pulse", 32'(period_done_o), 32'(exp_pd));
    chk("R8 last buffer pulse", 32'(buffer_done_o), 32'(exp_bd));
  endtask

  initial begin
    do_reset();
    chk("R1 active", 32'(active_o), 0);
    chk("R1 addr", addr_o, 0);
    chk("R1 count", 32'(byte_cnt_o), 0);
    chk("R1 period pulse", 32'(period_done_o), 0);
    chk("R1 buffer pulse", 32'(buffer_done_o), 0);

    cfg_base_i = 32'h0000_8000; cfg_nch_i = 4'd2; cfg_choff_i = 16'd32; cfg_split_i = 1'b0;
    cfg_psize_i = 16'd0; cfg_nper_i = 8'd2;
    start_i = 1'b1; @(negedge clk); start_i = 1'b0; adv_i = 1'b1; @(negedge clk); adv_i = 1'b0;
    chk("R3 zero size active", 32'(active_o), 0);
    chk("R3 zero size addr", addr_o, 0);
    chk("R3 zero size count", 32'(byte_cnt_o), 0);
    cfg_psize_i = 16'd64; cfg_nper_i = 8'd0;
    start_i = 1'b1; @(negedge clk); start_i = 1'b0; adv_i = 1'b1; @(negedge clk); adv_i = 1'b0;
    chk("R3 zero periods active", 32'(active_o), 0);
    chk("R3 zero periods addr", addr_o, 0);
    chk("R3 zero periods count", 32'(byte_cnt_o), 0);

    for (int s = 0; s < 2; s++)
      for (int c = 2; c <= 8; c += 2)
        for (int n = 1; n <= 3; n++)
          for (int k = 1; k <= 2; k++)
            run_cfg(s[0], c, 32 * c * k, n);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule